// File: doc/BRIEF.md
# Calendar Alarm Comparator with Latched Interrupt

This block watches a running calendar and raises an interrupt when the calendar reaches a programmed alarm time. The time itself is kept elsewhere. The block receives the current seconds, minutes, hours, weekday, day of month, month and year as BCD fields on its input ports.

Software programs the alarm through a simple register write port. Each alarm field has its own include bit. A field whose include bit is cleared takes no part in the comparison, so an alarm can ignore the weekday or fire every day at a given hour. Field writes land in a staging copy. A separate commit write moves all staged fields into the comparator at once, so a half-written alarm is never compared.

A match latches a sticky status bit. Software clears that bit by writing a one to it. A separate enable bit gates the status onto the interrupt line.

Top module: `calendar_alarm`

## Requirements
- R1: A write to a field register (address 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year) only updates the staged copy. Reading that address returns the committed value, which stays unchanged until a commit.
- R2: A write to address 7 with bit 15 set copies all seven staged fields and their include bits into the comparator. A write to address 7 with bit 15 clear changes nothing.
- R3: A field readback holds the committed value in bits [w-1:0] and the include bit in bit 15; all other bits read 0. The field widths w are 7, 7, 6, 3, 6, 5 and 8, in address order. Written bits above w are dropped.
- R4: A match happens when every included field equals the corresponding time input over the field width. Excluded fields, including the weekday, do not affect the match.
- R5: When no field is included, no match is ever produced and the status bit never sets.
- R6: Status bit 0 at address 9 sets only on the first cycle of a match. If software clears it while the match persists, it stays clear.
- R7: Once set, the status bit remains set after the time inputs move away from the alarm.
- R8: Writing address 9 with bit 0 = 1 clears the status bit. Writing it with bit 0 = 0 leaves the status bit unchanged.
- R9: If a new match begins in the same cycle as a clear write, the status bit ends up set.
- R10: Bit 0 of address 8 is the interrupt enable. The irq output is high exactly when both the status bit and the enable bit are 1.
- R11: After reset, every register reads 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tm_sec | input | 7 | Current seconds, BCD |
| tm_min | input | 7 | Current minutes, BCD |
| tm_hour | input | 6 | Current hours, BCD |
| tm_wday | input | 3 | Current weekday |
| tm_mday | input | 6 | Current day of month, BCD |
| tm_mon | input | 5 | Current month, BCD |
| tm_year | input | 8 | Current year offset, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Combinational read data |
| irq | output | 1 | Alarm interrupt |

## Verification
Two events can land in the same clock edge: a freshly detected match setting the status bit, and a software write-one clearing it. The bench provokes this by holding the time one second away from the alarm. At a single falling edge it then steps the time onto the alarm and issues the clear write. The status read back afterwards must be 1.

A reference model in the bench tracks staged values, committed values, the previous match and the status bit, cycle by cycle, from the stimulus alone. Every step of the per-field value sweeps is compared against that model.

// File: rtl/calarm_pkg.sv
// Shared constants, register addresses and field widths for the calendar alarm.
// Assumes seven calendar fields in the fixed order sec, min, hour, wday, mday, mon, year.
package calarm_pkg;
    localparam int NFIELD = 7;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 4;
    localparam int VAL_W  = 8;
    localparam int EN_BIT = 15;
    localparam int GO_BIT = 15;

    typedef enum logic [ADDR_W-1:0] {
        A_SEC    = 4'd0,
        A_MIN    = 4'd1,
        A_HOUR   = 4'd2,
        A_WDAY   = 4'd3,
        A_MDAY   = 4'd4,
        A_MON    = 4'd5,
        A_YEAR   = 4'd6,
        A_COMMIT = 4'd7,
        A_IEN    = 4'd8,
        A_STAT   = 4'd9
    } reg_addr_e;

    // Width in bits of each calendar field, indexed by field number.
    function automatic int field_width(input int idx);
        case (idx)
            0:       return 7;
            1:       return 7;
            2:       return 6;
            3:       return 3;
            4:       return 6;
            5:       return 5;
            default: return 8;
        endcase
    endfunction
endpackage

// File: rtl/calarm_regs.sv
// Staged and committed alarm field registers.
// Field writes go to a staging copy. A commit write moves every staged field
// and include bit into the committed copy in one cycle.
// Assumes at most one register write per cycle.
module calarm_regs
    import calarm_pkg::*;
#(
    parameter int NF = NFIELD,
    parameter int RW = REG_W,
    parameter int AW = ADDR_W,
    parameter int VW = VAL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [RW-1:0]      wr_data,
    output logic [NF-1:0][VW-1:0] act_val,
    output logic [NF-1:0]      act_en
);
    logic go;

    // Commit strobe: commit address with the trigger bit set.
    assign go = wr_en && (wr_addr == AW'(A_COMMIT)) && wr_data[GO_BIT];

    for (genvar g = 0; g < NF; g++) begin : g_fld
        localparam int FW = field_width(g);
        logic [FW-1:0] stg_v;
        logic          stg_e;
        logic [FW-1:0] act_v;
        logic          act_e;

        // Staging register: captures a write aimed at this field.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_v <= '0;
                stg_e <= 1'b0;
            end else if (wr_en && (wr_addr == AW'(g))) begin
                stg_v <= wr_data[FW-1:0];
                stg_e <= wr_data[EN_BIT];
            end
        end

        // Committed register: loads from staging on the commit strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_v <= '0;
                act_e <= 1'b0;
            end else if (go) begin
                act_v <= stg_v;
                act_e <= stg_e;
            end
        end

        assign act_val[g] = VW'(act_v);
        assign act_en[g]  = act_e;
    end
endmodule

// File: rtl/calarm_match.sv
// Combinational comparison of the committed alarm against the current time.
// An excluded field always counts as equal. With no field included the result is 0.
// Assumes the time inputs are zero-extended to VW bits.
module calarm_match
    import calarm_pkg::*;
#(
    parameter int NF = NFIELD,
    parameter int VW = VAL_W
) (
    input  logic [NF-1:0][VW-1:0] tm,
    input  logic [NF-1:0][VW-1:0] act_val,
    input  logic [NF-1:0]         act_en,
    output logic                  hit
);
    logic [NF-1:0] eq;

    for (genvar g = 0; g < NF; g++) begin : g_cmp
        localparam int FW = field_width(g);
        // Per-field equality over the field width, forced true when excluded.
        assign eq[g] = !act_en[g] || (tm[g][FW-1:0] == act_val[g][FW-1:0]);
    end

    // Match when every field agrees and at least one field is included.
    assign hit = (&eq) && (|act_en);
endmodule

// File: rtl/calarm_irq.sv
// Match edge detection, sticky write-one-to-clear status, and interrupt gating.
// A rising match beats a clear write arriving in the same cycle.
module calarm_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ien_wr,
    input  logic ien_d,
    input  logic clr_req,
    output logic status,
    output logic ien,
    output logic hit_q,
    output logic irq
);
    logic set_ev;

    assign set_ev = hit && !hit_q;

    // Remember the previous cycle's match to find its first cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit;
    end

    // Sticky status: set on a new match, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)       status <= 1'b0;
        else if (set_ev)  status <= 1'b1;
        else if (clr_req) status <= 1'b0;
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien <= 1'b0;
        else if (ien_wr) ien <= ien_d;
    end

    assign irq = status & ien;
endmodule

// File: rtl/calendar_alarm.sv
// Top of the calendar alarm: register port decode, read mux, and the three sub-blocks.
// Time fields arrive as BCD from an external counter; this block does not count time.
module calendar_alarm
    import calarm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [6:0]  tm_sec,
    input  logic [6:0]  tm_min,
    input  logic [5:0]  tm_hour,
    input  logic [2:0]  tm_wday,
    input  logic [5:0]  tm_mday,
    input  logic [4:0]  tm_mon,
    input  logic [7:0]  tm_year,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic [3:0]  rd_addr,
    output logic [15:0] rd_data,
    output logic        irq
);
    logic [NFIELD-1:0][VAL_W-1:0] tm;
    logic [NFIELD-1:0][VAL_W-1:0] act_val;
    logic [NFIELD-1:0]            act_en;
    logic hit, hit_q, status, ien, clr_req, ien_wr;

    // Gather the time fields into one array in address order.
    assign tm[0] = VAL_W'(tm_sec);
    assign tm[1] = VAL_W'(tm_min);
    assign tm[2] = VAL_W'(tm_hour);
    assign tm[3] = VAL_W'(tm_wday);
    assign tm[4] = VAL_W'(tm_mday);
    assign tm[5] = VAL_W'(tm_mon);
    assign tm[6] = VAL_W'(tm_year);

    assign clr_req = wr_en && (wr_addr == A_STAT) && wr_data[0];
    assign ien_wr  = wr_en && (wr_addr == A_IEN);

    calarm_regs #(.NF(NFIELD), .RW(REG_W), .AW(ADDR_W), .VW(VAL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .act_val (act_val),
        .act_en  (act_en)
    );

    calarm_match #(.NF(NFIELD), .VW(VAL_W)) u_match (
        .tm      (tm),
        .act_val (act_val),
        .act_en  (act_en),
        .hit     (hit)
    );

    calarm_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .ien_wr  (ien_wr),
        .ien_d   (wr_data[0]),
        .clr_req (clr_req),
        .status  (status),
        .ien     (ien),
        .hit_q   (hit_q),
        .irq     (irq)
    );

    // Read mux: committed fields, enable and status; other addresses read zero.
    always_comb begin
        int idx;
        rd_data = '0;
        idx = int'(rd_addr);
        if (idx < NFIELD) begin
            rd_data[VAL_W-1:0] = act_val[idx];
            rd_data[EN_BIT]    = act_en[idx];
        end else if (rd_addr == A_IEN) begin
            rd_data[0] = ien;
        end else if (rd_addr == A_STAT) begin
            rd_data[0] = status;
        end
    end
endmodule

// File: rtl/calendar_alarm_chk.sv
// Temporal checks on the calendar alarm, bound into the top module.
module calendar_alarm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hit,
    input logic        hit_q,
    input logic        status,
    input logic        ien,
    input logic        irq,
    input logic        clr_req,
    input logic [6:0]  act_en,
    input logic        wr_en,
    input logic [3:0]  wr_addr,
    input logic [15:0] wr_data
);
    // R10
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq);
    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr_req) |=> status);
    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !(hit && !hit_q)) |=> !status);
    // R9
    setwins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !hit_q) |=> status);
    // R5
    noen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en == 7'd0) |-> !hit);
    // R6
    once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> hit_q);
    // R2
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd7 && !wr_data[15]) |=> $stable(act_en));
endmodule

bind calendar_alarm calendar_alarm_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .hit_q   (hit_q),
    .status  (status),
    .ien     (ien),
    .irq     (irq),
    .clr_req (clr_req),
    .act_en  (act_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
);

// File: tb/sim_calendar_alarm.sv
`timescale 1ns/1ps
module sim_calendar_alarm;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  tm [7];
    logic        wr_en;
    logic [3:0]  wr_addr, rd_addr;
    logic [15:0] wr_data, rd_data;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    // Reference model state.
    logic [7:0] m_stg [7];
    logic       m_stge [7];
    logic [7:0] m_act [7];
    logic       m_acte [7];
    logic       m_ien, m_st, m_pm;

    // Alarm programme used by the tests.
    logic [7:0] al [7];
    logic       alen [7];

    always #2.5 clk = ~clk;

    calendar_alarm u0 (
        .clk(clk), .rst_n(rst_n),
        .tm_sec(tm[0][6:0]), .tm_min(tm[1][6:0]), .tm_hour(tm[2][5:0]),
        .tm_wday(tm[3][2:0]), .tm_mday(tm[4][5:0]), .tm_mon(tm[5][4:0]),
        .tm_year(tm[6]),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    function automatic int fw(input int i);
        int w [7] = '{7, 7, 6, 3, 6, 5, 8};
        return w[i];
    endfunction

    function automatic logic [7:0] msk(input int i);
        return 8'((1 << fw(i)) - 1);
    endfunction

    // Cycle model derived from the requirements.
    always @(posedge clk) begin
        logic mm;
        int   ne;
        if (!rst_n) begin
            for (int i = 0; i < 7; i++) begin
                m_stg[i] = 0; m_stge[i] = 0; m_act[i] = 0; m_acte[i] = 0;
            end
            m_ien = 0; m_st = 0; m_pm = 0;
        end else begin
            ne = 0; mm = 1;
            for (int i = 0; i < 7; i++)
                if (m_acte[i]) begin
                    ne++;
                    if ((tm[i] & msk(i)) != m_act[i]) mm = 0;
                end
            if (ne == 0) mm = 0;
            if (mm && !m_pm) m_st = 1;
            else if (wr_en && wr_addr == 9 && wr_data[0]) m_st = 0;
            m_pm = mm;
            if (wr_en) begin
                if (wr_addr < 7) begin
                    m_stg[wr_addr]  = wr_data[7:0] & msk(int'(wr_addr));
                    m_stge[wr_addr] = wr_data[15];
                end else if (wr_addr == 7 && wr_data[15]) begin
                    for (int i = 0; i < 7; i++) begin
                        m_act[i] = m_stg[i]; m_acte[i] = m_stge[i];
                    end
                end else if (wr_addr == 8) m_ien = wr_data[0];
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic chk_st(input string tag);
        logic [15:0] d;
        rd(4'd9, d);
        chk(tag, {15'd0, d[0]}, {15'd0, m_st});
        chk(tag, {15'd0, irq}, {15'd0, m_st & m_ien});
    endtask

    task automatic prog_all();
        for (int i = 0; i < 7; i++) wr(4'(i), {alen[i], 7'd0, al[i]});
        wr(4'd7, 16'h8000);
    endtask

    task automatic clear_if_set();
        if (m_st) wr(4'd9, 16'h0001);
    endtask

    task automatic sweep(input int f, input string tag);
        for (int v = 0; v < (1 << fw(f)); v++) begin
            tm[f] = 8'(v);
            tick();
            chk_st(tag);
            clear_if_set();
        end
        tm[f] = al[f];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] d;
        rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        for (int i = 0; i < 7; i++) tm[i] = 0;
        al = '{8'h30, 8'h45, 8'h12, 8'h03, 8'h15, 8'h06, 8'h25};
        for (int i = 0; i < 7; i++) alen[i] = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();

        // R11: every register reads zero after reset, irq low
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), d);
            chk("R11", d, 16'h0000);
        end
        chk("R11", {15'd0, irq}, 16'd0);

        // R1: staged write is not visible before commit
        wr(4'd0, 16'h8030);
        rd(4'd0, d); chk("R1", d, 16'h0000);
        // R2: commit address without trigger bit does nothing
        wr(4'd7, 16'h0000);
        rd(4'd0, d); chk("R2", d, 16'h0000);
        prog_all();
        rd(4'd0, d); chk("R2", d, 16'h8030);
        rd(4'd6, d); chk("R2", d, 16'h8025);

        // R3: bits above the field width drop, unused bits read zero
        wr(4'd0, 16'hFFFF);
        wr(4'd3, 16'h7FFF);
        wr(4'd7, 16'h8000);
        rd(4'd0, d); chk("R3", d, 16'h807F);
        rd(4'd3, d); chk("R3", d, 16'h0007);
        prog_all();
        wr(4'd8, 16'h0001);

        // R4: sweep every field with all others matching
        for (int f = 0; f < 7; f++) begin
            for (int j = 0; j < 7; j++) tm[j] = (j == f) ? 8'h00 : al[j];
            tick(); clear_if_set();
            sweep(f, "R4");
        end

        // R4: weekday excluded, any weekday value matches
        alen[3] = 0; prog_all();
        tm[0] = 8'h00; tick(); clear_if_set();
        for (int j = 0; j < 7; j++) tm[j] = al[j];
        tm[3] = 8'h06;
        tick();
        chk("R4", {15'd0, irq}, 16'd1);
        chk_st("R4");
        clear_if_set();
        sweep(3, "R4");

        // R5: no field included, never a match
        for (int i = 0; i < 7; i++) alen[i] = 0;
        prog_all();
        sweep(0, "R5");
        rd(4'd9, d); chk("R5", d, 16'h0000);

        // R6: set once, stays clear while match persists
        for (int i = 0; i < 7; i++) alen[i] = 1;
        prog_all();
        tm[0] = 8'h31; tick(); clear_if_set();
        tm[0] = 8'h30; tick();
        rd(4'd9, d); chk("R6", d, 16'h0001);
        wr(4'd9, 16'h0001);
        repeat (3) tick();
        rd(4'd9, d); chk("R6", d, 16'h0000);
        chk_st("R6");

        // R7: stays set after time moves on
        tm[0] = 8'h31; tick();
        tm[0] = 8'h30; tick();
        tm[0] = 8'h31; repeat (3) tick();
        rd(4'd9, d); chk("R7", d, 16'h0001);

        // R8: writing zero keeps status, writing one clears it
        wr(4'd9, 16'h0000);
        rd(4'd9, d); chk("R8", d, 16'h0001);
        wr(4'd9, 16'h0001);
        rd(4'd9, d); chk("R8", d, 16'h0000);

        // R10: irq follows status only when enabled
        tm[0] = 8'h30; tick();
        wr(4'd8, 16'h0000);
        chk("R10", {15'd0, irq}, 16'd0);
        rd(4'd9, d); chk("R10", d, 16'h0001);
        wr(4'd8, 16'h0001);
        chk("R10", {15'd0, irq}, 16'd1);

        // R9: new match and clear write in the same cycle, set wins
        tm[0] = 8'h31; tick();
        wr(4'd9, 16'h0001);
        rd(4'd9, d); chk("R9", d, 16'h0000);
        tm[0] = 8'h30;
        wr(4'd9, 16'h0001);
        rd(4'd9, d); chk("R9", d, 16'h0001);
        chk_st("R9");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule